// File: doc/BRIEF.md
# ADC Interrupt Status Controller

This block gathers the interrupt events of an auxiliary ADC and turns them into one interrupt request for the system interrupt controller. There are five event sources. One is a data-ready indication from the converter. The other four are digital comparators. Each comparator checks every valid ADC sample against its own programmed threshold. A per-comparator direction bit decides whether the event means the sample is above the threshold or below it.

Each source sets its status bit only on the rising edge of its condition. A condition that stays true raises no second event. A read of the status register returns the latched bits and clears them. A separate mask register decides which latched bits may drive the interrupt output. Masked events are still latched and can be read. Software reaches the status, mask, threshold and direction registers through a simple register port. A read returns its data in the same cycle as the read strobe.

Top module: `adc_irq_ctrl`

## Requirements
- R1: After reset the status reads 0x0000, the mask reads 0x01F0 (all five sources masked), every threshold and the direction register read 0, and irq_o is low.
- R2: A rising edge of drdy_i sets status bit 8. If drdy_i stays high, the bit is not set again after a status read clears it.
- R3: When direction bit n-1 is 1, comparator n (n = 1..4) sets status bit 3+n (DCOMPn at bits 4..7) when a valid sample first goes strictly above threshold n. A sample equal to the threshold counts as not above.
- R4: When direction bit n-1 is 0, comparator n sets status bit 3+n when a valid sample first goes strictly below threshold n. A sample equal to the threshold counts as not below, and while the condition holds no further event is raised.
- R5: A sample presented while smp_valid_i is low changes no comparator state and sets no status bit.
- R6: A read of address 0x1A returns the status in bits 8:4 and clears every bit that saw no new event in that cycle.
- R7: An event that arrives in the same cycle as a status read is still set after the read.
- R8: Reads and writes of any other address, including the ADC result addresses 0x98 to 0x9F, leave the status bits unchanged. Those result addresses read 0.
- R9: The mask register sits at address 0x22, bits 8:4, aligned with the status bits, where 1 means masked. irq_o is high exactly when some set status bit is unmasked, and it follows a mask change in the cycle after the write.
- R10: Masked events are still latched in the status register and are returned by a status read.
- R11: Bits 15:9 and 3:0 of the status and mask registers read 0. Writes to those bits are ignored, and writes to the status address change nothing.
- R12: Threshold n is read and written at address 0x3F+n, bits DATA_W-1:0. The direction register is at address 0x44, bits 3:0, where bit n-1 belongs to comparator n. All other bits of these registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| drdy_i | input | 1 | Data-ready condition from the converter |
| smp_valid_i | input | 1 | Strobe that qualifies smp_data_i |
| smp_data_i | input | DATA_W | ADC sample compared against the four thresholds |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, valid in the cycle of reg_re_i, 0 otherwise |
| irq_o | output | 1 | First-level interrupt request |

## Verification
The bench builds the block with DATA_W set to 8 and ADDR_W left at 8. With these values, samples that sit exactly on a threshold, just above it and just below it are all easy to drive. The full 16-bit register word also has unused threshold bits, so the truncation of wide writes can be checked. Shared samples drive all four comparators at once, with mixed directions, so one sample can raise several events while held conditions stay silent. A sample and a status read are placed in the same cycle to show that the event survives the clear.

// File: rtl/adc_irq_pkg.sv
package adc_irq_pkg;
  localparam int NUM_CMP  = 4;
  localparam int NUM_SRC  = NUM_CMP + 1;
  localparam int SRC_LSB  = 4;   // DCOMP1 lands on register bit 4
  localparam int DRDY_IDX = NUM_CMP;
  localparam int REG_W    = 16;

  localparam int ADR_STS  = 'h1A;
  localparam int ADR_MSK  = 'h22;
  localparam int ADR_THR0 = 'h40;
  localparam int ADR_DIR  = 'h44;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STS,
    SEL_MSK,
    SEL_THR,
    SEL_DIR
  } reg_sel_e;
endpackage

// File: rtl/adc_irq_rise.sv
module adc_irq_rise (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic evt_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign evt_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/adc_irq_cmp.sv
module adc_irq_cmp #(
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_valid_i,
  input  logic [DATA_W-1:0] smp_data_i,
  input  logic [DATA_W-1:0] thr_i,
  input  logic              above_i,
  output logic              evt_o
);
  logic hit;
  logic cond_q;

  // strict compare: equality is neither above nor below
  assign hit = above_i ? (smp_data_i > thr_i) : (smp_data_i < thr_i);

  // condition level only advances on qualified samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cond_q <= 1'b0;
    else if (smp_valid_i) cond_q <= hit;
  end

  assign evt_o = smp_valid_i & hit & ~cond_q;
endmodule

// File: rtl/adc_irq_status.sv
module adc_irq_status
  import adc_irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               clr_i,
  input  logic [NUM_SRC-1:0] msk_i,
  output logic [NUM_SRC-1:0] sts_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] sts_q;
  logic [NUM_SRC-1:0] sts_d;

  // new events win over the read clear
  always_comb begin
    sts_d = clr_i ? '0 : sts_q;
    sts_d = sts_d | evt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= sts_d;
  end

  assign sts_o = sts_q;
  assign irq_o = |(sts_q & ~msk_i);
endmodule

// File: rtl/adc_irq_regs.sv
module adc_irq_regs
  import adc_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 12
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           reg_we_i,
  input  logic                           reg_re_i,
  input  logic [ADDR_W-1:0]              reg_addr_i,
  input  logic [REG_W-1:0]               reg_wdata_i,
  input  logic [NUM_SRC-1:0]             sts_i,
  output logic [REG_W-1:0]               reg_rdata_o,
  output logic                           sts_rd_o,
  output logic [NUM_SRC-1:0]             msk_o,
  output logic [NUM_CMP-1:0][DATA_W-1:0] thr_o,
  output logic [NUM_CMP-1:0]             dir_o
);
  localparam int IDX_W = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1;

  reg_sel_e                       sel;
  logic [IDX_W-1:0]               idx;
  logic [NUM_SRC-1:0]             msk_q;
  logic [NUM_CMP-1:0][DATA_W-1:0] thr_q;
  logic [NUM_CMP-1:0]             dir_q;
  logic                           unused_wdata;

  assign unused_wdata = ^reg_wdata_i;

  always_comb begin
    sel = SEL_NONE;
    idx = '0;
    if (reg_addr_i == ADDR_W'(ADR_STS))      sel = SEL_STS;
    else if (reg_addr_i == ADDR_W'(ADR_MSK)) sel = SEL_MSK;
    else if (reg_addr_i == ADDR_W'(ADR_DIR)) sel = SEL_DIR;
    else begin
      for (int i = 0; i < NUM_CMP; i++) begin
        if (reg_addr_i == ADDR_W'(ADR_THR0 + i)) begin
          sel = SEL_THR;
          idx = IDX_W'(i);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msk_q <= '1;
      thr_q <= '0;
      dir_q <= '0;
    end else if (reg_we_i) begin
      case (sel)
        SEL_MSK: msk_q      <= reg_wdata_i[SRC_LSB +: NUM_SRC];
        SEL_THR: thr_q[idx] <= reg_wdata_i[DATA_W-1:0];
        SEL_DIR: dir_q      <= reg_wdata_i[NUM_CMP-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_re_i) begin
      case (sel)
        SEL_STS: reg_rdata_o[SRC_LSB +: NUM_SRC] = sts_i;
        SEL_MSK: reg_rdata_o[SRC_LSB +: NUM_SRC] = msk_q;
        SEL_THR: reg_rdata_o[DATA_W-1:0]         = thr_q[idx];
        SEL_DIR: reg_rdata_o[NUM_CMP-1:0]        = dir_q;
        default: ;
      endcase
    end
  end

  assign sts_rd_o = reg_re_i && (sel == SEL_STS);
  assign msk_o    = msk_q;
  assign thr_o    = thr_q;
  assign dir_o    = dir_q;
endmodule

// File: rtl/adc_irq_ctrl.sv
module adc_irq_ctrl
  import adc_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              drdy_i,
  input  logic              smp_valid_i,
  input  logic [DATA_W-1:0] smp_data_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [15:0]       reg_wdata_i,
  output logic [15:0]       reg_rdata_o,
  output logic              irq_o
);
  logic [NUM_SRC-1:0]             evt;
  logic [NUM_SRC-1:0]             sts_q;
  logic [NUM_SRC-1:0]             msk_q;
  logic [NUM_CMP-1:0][DATA_W-1:0] thr;
  logic [NUM_CMP-1:0]             dir;
  logic                           sts_rd;

  adc_irq_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_re_i    (reg_re_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .sts_i       (sts_q),
    .reg_rdata_o (reg_rdata_o),
    .sts_rd_o    (sts_rd),
    .msk_o       (msk_q),
    .thr_o       (thr),
    .dir_o       (dir)
  );

  adc_irq_rise i_drdy_rise (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (drdy_i),
    .evt_o  (evt[DRDY_IDX])
  );

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    adc_irq_cmp #(
      .DATA_W (DATA_W)
    ) i_cmp (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .smp_valid_i (smp_valid_i),
      .smp_data_i  (smp_data_i),
      .thr_i       (thr[g]),
      .above_i     (dir[g]),
      .evt_o       (evt[g])
    );
  end

  adc_irq_status i_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt),
    .clr_i  (sts_rd),
    .msk_i  (msk_q),
    .sts_o  (sts_q),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/adc_irq_chk.sv
module adc_irq_chk
  import adc_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               reg_re_i,
  input logic [ADDR_W-1:0]  reg_addr_i,
  input logic [15:0]        reg_rdata_o,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] sts,
  input logic [NUM_SRC-1:0] msk,
  input logic [NUM_SRC-1:0] evt
);
  logic sts_rd;
  logic reg_rd;

  assign sts_rd = reg_re_i && (reg_addr_i == ADDR_W'(ADR_STS));
  assign reg_rd = reg_re_i && (reg_addr_i == ADDR_W'(ADR_STS) ||
                               reg_addr_i == ADDR_W'(ADR_MSK));

  assert_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_rd && evt == '0) |=> sts == '0);

  assert_keep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt != '0) |=> ((sts & $past(evt)) == $past(evt)));

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sts_rd |=> ((sts & $past(sts)) == $past(sts)));

  assert_masked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&msk) |-> !irq_o);

  assert_unused_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd |-> (reg_rdata_o[15:9] == '0 && reg_rdata_o[3:0] == '0));
endmodule

bind adc_irq_ctrl adc_irq_chk #(
  .ADDR_W (ADDR_W)
) i_adc_irq_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_re_i    (reg_re_i),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o),
  .irq_o       (irq_o),
  .sts         (sts_q),
  .msk         (msk_q),
  .evt         (evt)
);

// File: tb/test_adc_irq_ctrl.sv
module test_adc_irq_ctrl;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam logic [AW-1:0] A_STS = 8'h1A;
  localparam logic [AW-1:0] A_MSK = 8'h22;
  localparam logic [AW-1:0] A_DIR = 8'h44;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          drdy = 1'b0;
  logic          valid = 1'b0;
  logic [DW-1:0] data = '0;
  logic          we = 1'b0;
  logic          re = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0]   wdata = '0;
  logic [15:0]   rdata;
  logic          irq;
  int            n_chk = 0;
  int            n_err = 0;

  always #10 clk = ~clk;

  adc_irq_ctrl #(.ADDR_W(AW), .DATA_W(DW)) i_adc_irq_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .drdy_i      (drdy),
    .smp_valid_i (valid),
    .smp_data_i  (data),
    .reg_we_i    (we),
    .reg_re_i    (re),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic reg_wr(logic [AW-1:0] a, logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [AW-1:0] a, logic [15:0] exp);
    @(negedge clk); re = 1'b1; addr = a;
    #1 check(req, rdata, exp);
    @(negedge clk); re = 1'b0;
  endtask

  task automatic sample(logic [DW-1:0] d);
    @(negedge clk); valid = 1'b1; data = d;
    @(negedge clk); valid = 1'b0;
  endtask

  task automatic drdy_pulse();
    @(negedge clk); drdy = 1'b1;
    @(negedge clk); drdy = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 irq", {15'd0, irq}, 16'h0);
    rd_chk("R1 status", A_STS, 16'h0000);
    rd_chk("R1 mask", A_MSK, 16'h01F0);
    rd_chk("R1 dir", A_DIR, 16'h0000);
    for (int i = 0; i < 4; i++) rd_chk("R1 thr", AW'(8'h40 + i), 16'h0000);
  endtask

  task automatic t_drdy();
    @(negedge clk); drdy = 1'b1;
    repeat (3) @(negedge clk);
    rd_chk("R2 edge sets bit 8", A_STS, 16'h0100);
    rd_chk("R2 held level no re-set", A_STS, 16'h0000);
    drdy = 1'b0;
    drdy_pulse();
    rd_chk("R2 second edge", A_STS, 16'h0100);
    rd_chk("R6 cleared by read", A_STS, 16'h0000);
  endtask

  task automatic t_config();
    reg_wr(8'h40, 16'hAB64);
    reg_wr(8'h41, 16'd110);
    reg_wr(8'h42, 16'd120);
    reg_wr(8'h43, 16'd130);
    reg_wr(A_DIR, 16'hFFF5);
    rd_chk("R12 thr1 truncated", 8'h40, 16'd100);
    rd_chk("R12 thr2", 8'h41, 16'd110);
    rd_chk("R12 thr3", 8'h42, 16'd120);
    rd_chk("R12 thr4", 8'h43, 16'd130);
    rd_chk("R12 dir", A_DIR, 16'h0005);
  endtask

  // cmp1/cmp3 above, cmp2/cmp4 below; thresholds 100/110/120/130
  task automatic t_compare();
    sample(8'd50);
    rd_chk("R4 below events DCOMP2 DCOMP4", A_STS, 16'h00A0);
    sample(8'd105);
    rd_chk("R3 above event DCOMP1, R4 held no repeat", A_STS, 16'h0010);
    sample(8'd125);
    rd_chk("R3 above event DCOMP3", A_STS, 16'h0040);
    sample(8'd130);
    rd_chk("R4 equal is not below", A_STS, 16'h0000);
    sample(8'd129);
    rd_chk("R4 below again DCOMP4", A_STS, 16'h0080);
    sample(8'd120);
    rd_chk("R3 equal is not above", A_STS, 16'h0000);
  endtask

  task automatic t_valid_gate();
    @(negedge clk); valid = 1'b0; data = 8'd121;
    repeat (2) @(negedge clk);
    rd_chk("R5 invalid sample ignored", A_STS, 16'h0000);
    sample(8'd121);
    rd_chk("R5 valid sample counted", A_STS, 16'h0040);
  endtask

  task automatic t_coincide();
    sample(8'd50);
    @(negedge clk); re = 1'b1; addr = A_STS; valid = 1'b1; data = 8'd125;
    #1 check("R6 read returns pending bits", rdata, 16'h0020);
    @(negedge clk); re = 1'b0; valid = 1'b0;
    rd_chk("R7 event during read kept", A_STS, 16'h0050);
  endtask

  task automatic t_other_reads();
    drdy_pulse();
    for (int i = 0; i < 8; i++) rd_chk("R8 result address reads 0", AW'(8'h98 + i), 16'h0000);
    reg_wr(8'h98, 16'hFFFF);
    rd_chk("R8 status survives other accesses", A_STS, 16'h0100);
  endtask

  task automatic t_mask();
    drdy_pulse();
    check("R10 masked event no irq", {15'd0, irq}, 16'h0);
    rd_chk("R10 masked event latched", A_STS, 16'h0100);
    reg_wr(A_MSK, 16'h00F0);
    check("R9 unmasked but empty", {15'd0, irq}, 16'h0);
    drdy_pulse();
    check("R9 unmasked event raises irq", {15'd0, irq}, 16'h1);
    rd_chk("R6 read returns drdy", A_STS, 16'h0100);
    check("R9 irq drops after clear", {15'd0, irq}, 16'h0);
    reg_wr(A_MSK, 16'h01F0);
    drdy_pulse();
    check("R9 masked pending no irq", {15'd0, irq}, 16'h0);
    reg_wr(A_MSK, 16'h00F0);
    check("R9 unmask pending raises irq", {15'd0, irq}, 16'h1);
    rd_chk("R9 pending read", A_STS, 16'h0100);
    reg_wr(A_MSK, 16'hFFFF);
    rd_chk("R11 mask unused bits", A_MSK, 16'h01F0);
    drdy_pulse();
    reg_wr(A_STS, 16'h0000);
    reg_wr(A_STS, 16'hFFFF);
    rd_chk("R11 status write ignored", A_STS, 16'h0100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_drdy();
    t_config();
    t_compare();
    t_valid_gate();
    t_coincide();
    t_other_reads();
    t_mask();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule